// File: doc/BRIEF.md
# Key Blob Error Status Controller

This block keeps the error and status state of a flash decryption unit that serves four key contexts. A key-unwrap engine, which lies outside this block, reports results as single-cycle pulses: one integrity-fault line per context and one completion line. The block turns these pulses into sticky status. It keeps a summary error flag and a vector that records which contexts failed. It also drives an interrupt request that software can mask.

Software reaches the block through a small word-wide register port. One word holds the configuration: interrupt mask, test force, unwrap enable and block enable. The other word holds the status. Both words read back combinationally. A write takes effect at the next clock edge. Software clears the error state by writing 1 to the summary bit of the status word. For test, software can raise the summary flag without a real fault. A flag raised this way comes with an empty context vector, so a forced error can be told apart from a genuine one.

Top module: `kbs_status_ctrl`

## Requirements
- R1: Any nonzero `ctx_err_i` sets the summary error flag (status bit 0). The flag stays 1 until it is cleared.
- R2: A fault pulse on context n sets status bit 16+n. The vector bits accumulate over pulses until they are cleared.
- R3: Writing status with bit 0 = 1 clears both the summary flag and the context vector. A status write with bit 0 = 0 has no effect. No other status bit can be written.
- R4: Writing configuration with bit 1 = 1 sets the summary flag and zeroes the context vector. This bit is not stored and reads back as 0.
- R5: When several events fall in the same cycle, a real fault wins over a force or a clear. In that case the flag ends at 1 and the faulting contexts are recorded on top of the vector.
- R6: `irq_o` is registered. In each cycle it equals the AND of the interrupt enable (configuration bit 0) and the summary flag, both taken from the previous cycle.
- R7: A pulse on `unwrap_done_i` sets the done bit (status bit 31) only while unwrap enable (configuration bit 2) is 1. When unwrap enable is 1, the done bit reads as the stored done state. When unwrap enable is 0, the done bit reads 0. One cycle after unwrap enable goes to 0, the stored done state is discarded.
- R8: Status bit 29 mirrors block enable (configuration bit 3). Status bit 30 mirrors unwrap enable.
- R9: Address 0 selects the configuration word and address 1 selects the status word. Configuration bits 0, 2 and 3 read back as written. Any other address reads 0, and writes to it are ignored.
- R10: After reset, all configuration bits, all status bits and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word select for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word |
| ctx_err_i | input | NUM_CTX | Per-context integrity fault pulses |
| unwrap_done_i | input | 1 | Unwrap completion pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach from the ports is a collision: a clear or a force write landing in the same cycle as a real fault pulse. A second awkward case is a force write arriving while the vector already holds bits. The vector table drives these collisions by putting a register write and a fault pulse in one row. Every row is followed by an idle cycle, and the idle cycle exposes the settled status word and the one-cycle-late interrupt. The done-discard case is reached through a sequence of rows: enable unwrap, pulse done, disable unwrap, then re-enable it and confirm the done bit stays 0.

// File: rtl/kbs_pkg.sv
package kbs_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned VEC_MAX = 12;

  // configuration word fields
  localparam int unsigned CFG_IE_BIT    = 0;
  localparam int unsigned CFG_FORCE_BIT = 1;
  localparam int unsigned CFG_KBEN_BIT  = 2;
  localparam int unsigned CFG_BLKEN_BIT = 3;

  // status word fields
  localparam int unsigned STA_ERR_BIT  = 0;
  localparam int unsigned STA_VEC_LSB  = 16;
  localparam int unsigned STA_BLK_BIT  = 29;
  localparam int unsigned STA_KBEN_BIT = 30;
  localparam int unsigned STA_DONE_BIT = 31;

  // word select
  localparam int unsigned SEL_CFG = 0;
  localparam int unsigned SEL_STA = 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic blk_en;
    logic kb_en;
    logic irq_en;
  } cfg_t;

  function automatic word_t pack_cfg(input cfg_t c);
    word_t w;
    w = '0;
    w[CFG_IE_BIT]    = c.irq_en;
    w[CFG_KBEN_BIT]  = c.kb_en;
    w[CFG_BLKEN_BIT] = c.blk_en;
    return w;
  endfunction

  function automatic word_t pack_status(input logic done, input logic kbe,
                                        input logic blk, input logic [VEC_MAX-1:0] vec,
                                        input logic err);
    word_t w;
    w = '0;
    w[STA_ERR_BIT]                     = err;
    w[STA_VEC_LSB +: VEC_MAX]          = vec;
    w[STA_BLK_BIT]                     = blk;
    w[STA_KBEN_BIT]                    = kbe;
    w[STA_DONE_BIT]                    = done;
    return w;
  endfunction

endpackage

// File: rtl/kbs_cfg_regs.sv
module kbs_cfg_regs
  import kbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  word_t wdata_i,
  output cfg_t  cfg_o,
  output logic  force_o,
  output word_t cfg_rd_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q.irq_en <= wdata_i[CFG_IE_BIT];
      cfg_q.kb_en  <= wdata_i[CFG_KBEN_BIT];
      cfg_q.blk_en <= wdata_i[CFG_BLKEN_BIT];
    end
  end

  assign force_o  = wr_i && wdata_i[CFG_FORCE_BIT];
  assign cfg_o    = cfg_q;
  assign cfg_rd_o = pack_cfg(cfg_q);

  assert_cfg_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cfg_q.irq_en == $past(wdata_i[CFG_IE_BIT]) &&
              cfg_q.kb_en  == $past(wdata_i[CFG_KBEN_BIT]) &&
              cfg_q.blk_en == $past(wdata_i[CFG_BLKEN_BIT])));

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_q));

  assert_force_rd0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_o[CFG_FORCE_BIT] == 1'b0);

endmodule

// File: rtl/kbs_err_tracker.sv
module kbs_err_tracker #(
  parameter int unsigned NUM_CTX = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTX-1:0] ctx_err_i,
  input  logic               force_i,
  input  logic               clr_i,
  output logic               err_o,
  output logic [NUM_CTX-1:0] vec_o
);

  typedef struct packed {
    logic               err;
    logic [NUM_CTX-1:0] vec;
  } est_t;

  // real fault > force > clear
  function automatic est_t step(input est_t cur, input logic [NUM_CTX-1:0] hits,
                                input logic frc, input logic clr);
    est_t nx;
    nx = cur;
    if (|hits) begin
      nx.err = 1'b1;
      nx.vec = cur.vec | hits;
    end else if (frc) begin
      nx.err = 1'b1;
      nx.vec = '0;
    end else if (clr) begin
      nx.err = 1'b0;
      nx.vec = '0;
    end
    return nx;
  endfunction

  est_t st_q, st_d;
  logic real_hit, force_take, clr_take;

  assign real_hit   = |ctx_err_i;
  assign force_take = force_i && !real_hit;
  assign clr_take   = clr_i && !real_hit && !force_i;
  assign st_d       = step(st_q, ctx_err_i, force_i, clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign err_o = st_q.err;
  assign vec_o = st_q.vec;

  assert_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_hit |=> err_o);

  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);

  assert_vec_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_hit |=> ((vec_o & $past(ctx_err_i)) == $past(ctx_err_i)));

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_take |=> (!err_o && vec_o == '0));

  assert_vec_needs_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> vec_o == '0);

  assert_force_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_take |=> (err_o && vec_o == '0));

  assert_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (real_hit && (clr_i || force_i)) |=> (err_o && vec_o != '0));

endmodule

// File: rtl/kbs_done_tracker.sv
module kbs_done_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kb_en_i,
  input  logic done_i,
  output logic done_o
);

  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_q <= 1'b0;
    else if (kb_en_i) done_q <= done_q | done_i;
    else              done_q <= 1'b0;
  end

  assign done_o = done_q && kb_en_i;

  assert_done_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && kb_en_i) |=> done_q);

  assert_done_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kb_en_i |=> !done_q);

endmodule

// File: rtl/kbs_status_ctrl.sv
module kbs_status_ctrl
  import kbs_pkg::*;
#(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_CTX-1:0] ctx_err_i,
  input  logic               unwrap_done_i,
  output logic               irq_o
);

  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(SEL_CFG);
  localparam logic [ADDR_W-1:0] ADDR_STA = ADDR_W'(SEL_STA);

  logic               cfg_wr, sta_clr, force_pulse;
  cfg_t               cfg_q;
  word_t              cfg_word, sta_word;
  logic               err_flag, done_flag;
  logic [NUM_CTX-1:0] err_vec;
  logic               irq_q;

  assign cfg_wr  = reg_wr_i && (reg_addr_i == ADDR_CFG);
  assign sta_clr = reg_wr_i && (reg_addr_i == ADDR_STA) && reg_wdata_i[STA_ERR_BIT];

  kbs_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .wdata_i  (reg_wdata_i),
    .cfg_o    (cfg_q),
    .force_o  (force_pulse),
    .cfg_rd_o (cfg_word)
  );

  kbs_err_tracker #(.NUM_CTX(NUM_CTX)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctx_err_i (ctx_err_i),
    .force_i   (force_pulse),
    .clr_i     (sta_clr),
    .err_o     (err_flag),
    .vec_o     (err_vec)
  );

  kbs_done_tracker u_done (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kb_en_i (cfg_q.kb_en),
    .done_i  (unwrap_done_i),
    .done_o  (done_flag)
  );

  assign sta_word = pack_status(done_flag, cfg_q.kb_en, cfg_q.blk_en,
                                VEC_MAX'(err_vec), err_flag);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CFG: reg_rdata_o = cfg_word;
      ADDR_STA: reg_rdata_o = sta_word;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= cfg_q.irq_en && err_flag;
  end

  assign irq_o = irq_q;

  assert_irq_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(cfg_q.irq_en && err_flag));

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != ADDR_CFG && reg_addr_i != ADDR_STA) |-> reg_rdata_o == '0);

endmodule

// File: tb/kbs_status_ctrl_tb_top.sv
module kbs_status_ctrl_tb_top;

  localparam int NUM_CTX = 4;
  localparam int ADDR_W  = 2;

  typedef struct packed {
    logic [23:0] tag;
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  errs;
    logic        done;
    logic [31:0] exp_stat;
    logic        exp_irq;
  } vec_t;

  // cfg: bit0 irq enable, bit1 force, bit2 unwrap enable, bit3 block enable
  // status: bit0 err, 19:16 contexts, 29 block en, 30 unwrap en, 31 done
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{"R10", 1'b1, 2'd0, 32'h0000_0000, 4'b0000, 1'b0, 32'h0000_0000, 1'b0},
    '{"R1 ", 1'b0, 2'd1, 32'h0000_0000, 4'b0010, 1'b0, 32'h0002_0001, 1'b0},
    '{"R2 ", 1'b0, 2'd1, 32'h0000_0000, 4'b1000, 1'b0, 32'h000A_0001, 1'b0},
    '{"R6 ", 1'b1, 2'd0, 32'h0000_0001, 4'b0000, 1'b0, 32'h000A_0001, 1'b1},
    '{"R3 ", 1'b1, 2'd1, 32'h0000_0000, 4'b0000, 1'b0, 32'h000A_0001, 1'b1},
    '{"R3 ", 1'b1, 2'd1, 32'h0000_0001, 4'b0000, 1'b0, 32'h0000_0000, 1'b0},
    '{"R4 ", 1'b1, 2'd0, 32'h0000_0003, 4'b0000, 1'b0, 32'h0000_0001, 1'b1},
    '{"R2 ", 1'b0, 2'd1, 32'h0000_0000, 4'b0100, 1'b0, 32'h0004_0001, 1'b1},
    '{"R4 ", 1'b1, 2'd0, 32'h0000_0003, 4'b0000, 1'b0, 32'h0000_0001, 1'b1},
    '{"R5 ", 1'b1, 2'd1, 32'h0000_0001, 4'b0001, 1'b0, 32'h0001_0001, 1'b1},
    '{"R3 ", 1'b1, 2'd1, 32'h0000_0001, 4'b0000, 1'b0, 32'h0000_0000, 1'b0},
    '{"R5 ", 1'b1, 2'd0, 32'h0000_0003, 4'b0100, 1'b0, 32'h0004_0001, 1'b1},
    '{"R3 ", 1'b1, 2'd1, 32'h0000_0001, 4'b0000, 1'b0, 32'h0000_0000, 1'b0},
    '{"R7 ", 1'b0, 2'd1, 32'h0000_0000, 4'b0000, 1'b1, 32'h0000_0000, 1'b0},
    '{"R8 ", 1'b1, 2'd0, 32'h0000_0005, 4'b0000, 1'b0, 32'h4000_0000, 1'b0},
    '{"R7 ", 1'b0, 2'd1, 32'h0000_0000, 4'b0000, 1'b1, 32'hC000_0000, 1'b0},
    '{"R8 ", 1'b1, 2'd0, 32'h0000_000D, 4'b0000, 1'b0, 32'hE000_0000, 1'b0},
    '{"R7 ", 1'b1, 2'd0, 32'h0000_0009, 4'b0000, 1'b0, 32'h2000_0000, 1'b0},
    '{"R2 ", 1'b0, 2'd1, 32'h0000_0000, 4'b1111, 1'b0, 32'h200F_0001, 1'b1},
    '{"R6 ", 1'b1, 2'd0, 32'h0000_0008, 4'b0000, 1'b0, 32'h200F_0001, 1'b0},
    '{"R9 ", 1'b1, 2'd2, 32'hFFFF_FFFF, 4'b0000, 1'b0, 32'h200F_0001, 1'b0},
    '{"R3 ", 1'b1, 2'd1, 32'hFFFF_FFFE, 4'b0000, 1'b0, 32'h200F_0001, 1'b0},
    '{"R7 ", 1'b1, 2'd0, 32'h0000_000C, 4'b0000, 1'b0, 32'h600F_0001, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               reg_wr = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic [NUM_CTX-1:0] ctx_err = '0;
  logic               done_p = 1'b0;
  logic               irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  kbs_status_ctrl #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reg_wr_i      (reg_wr),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .ctx_err_i     (ctx_err),
    .unwrap_done_i (done_p),
    .irq_o         (irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr  = 1'b0;
    ctx_err = '0;
    done_p  = 1'b0;
  endtask

  task automatic read_word(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10: state held in reset
    read_word(2'd1, rd); check("R10", "status in reset", rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(2'd1, rd); check("R10", "status after reset", rd, 32'h0);
    read_word(2'd0, rd); check("R10", "config after reset", rd, 32'h0);
    check("R10", "irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr    = VECS[i].wr;
      reg_addr  = VECS[i].addr;
      reg_wdata = VECS[i].wdata;
      ctx_err   = VECS[i].errs;
      done_p    = VECS[i].done;
      @(negedge clk);
      idle();
      read_word(2'd1, rd);
      check(string'(VECS[i].tag), $sformatf("status row %0d", i), rd, VECS[i].exp_stat);
      @(negedge clk);
      #1;
      check(string'(VECS[i].tag), $sformatf("irq row %0d", i), {31'b0, irq},
            {31'b0, VECS[i].exp_irq});
    end

    // R9: config readback, force bit not stored; R4: force leaves empty vector
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_000F;
    @(negedge clk);
    idle();
    read_word(2'd0, rd); check("R9", "config readback", rd, 32'h0000_000D);
    read_word(2'd1, rd); check("R4", "status after force", rd, 32'h6000_0001);
    read_word(2'd3, rd); check("R9", "unmapped read", rd, 32'h0);

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    read_word(2'd1, rd); check("R10", "status after mid reset", rd, 32'h0);
    read_word(2'd0, rd); check("R10", "config after mid reset", rd, 32'h0);
    check("R10", "irq after mid reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule